// File: doc/BRIEF.md
# Ordered Node-Occupancy Commit Arbiter

This block decides which in-flight transactions may commit when memory is divided into a number of nodes. Each requester presents a commit set. The commit set is a bitmask in which bit n is set when the transaction read or wrote node n. The arbiter gives out occupancy of nodes and never lets two requesters hold the same node. A requester's ready flag rises once it holds every node of its set. The transaction can then commit, and it hands all of its nodes back with a one-cycle done pulse.

There are two ways to acquire nodes, chosen per request. In ordered mode, a requester takes the lowest node it still lacks, one node per cycle. If that node is held by someone else, it waits. Because every requester climbs in ascending order, a circular wait cannot form. In speculative mode, a requester first tries to take its whole set in a single cycle. If any node is refused, it keeps only the nodes below the first refused node and continues from there in ordered mode. Requesters whose sets do not overlap proceed side by side.

Top module: `commit_node_arbiter`

## Requirements
- R1: After reset no requester is ready, no node is held, and every node-busy flag is low.
- R2: A node is held by at most one requester at any time, and node_busy_o[n] is high exactly when some requester holds node n.
- R3: In ordered mode a request is accepted on the edge where req_valid_i is sampled. On each later edge the requester gains at most one node: the lowest node of its set it does not yet hold, and only if that node was free during the cycle.
- R4: ready_o[r] is high exactly when requester r holds every node of its accepted set. With no contention, an ordered request for m nodes is ready on the (m+1)-th edge counted from the accepting edge inclusive.
- R5: Requesters with disjoint sets acquire their nodes concurrently, each at its uncontended pace.
- R6: In speculative mode, when every node of the set is free and uncontested, the requester holds the whole set and is ready on the second edge after acceptance.
- R7: When a speculative grab is refused on any node, the requester keeps only the nodes below the lowest refused node. It leaves all higher nodes free and then continues in ordered mode.
- R8: When several requesters want the same free node in the same cycle, the requester with the lowest index gets it.
- R9: A done_i pulse from a non-idle requester frees all of its nodes and returns it to idle on that edge. The freed nodes can be granted to another requester on the following edge.
- R10: req_valid_i is ignored while a requester is not idle: its held nodes and ready flag stay unchanged. done_i is ignored for an idle requester.
- R11: A request with an empty set becomes ready on the second edge after acceptance, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | NUM_REQ | Per-requester pulse starting an acquisition |
| req_spec_i | input | NUM_REQ | Per-requester mode with the request: 1 speculative, 0 ordered |
| req_set_i | input | NUM_REQ*NUM_NODES | Commit sets; requester r uses bits [r*NUM_NODES +: NUM_NODES] |
| done_i | input | NUM_REQ | Per-requester pulse releasing all held nodes |
| ready_o | output | NUM_REQ | Requester holds its full set and may commit |
| held_o | output | NUM_REQ*NUM_NODES | Nodes currently held, same layout as req_set_i |
| node_busy_o | output | NUM_NODES | Node is held by some requester |

## Verification
A corrupted owner register shows up on held_o and node_busy_o on the very next edge. It appears either as a node claimed twice or as a node that stays busy after done. A wrong acquisition pointer shows up as an out-of-order bit appearing in held_o within one cycle of climbing. A wrong fallback mask exposes a node above the refused one as busy on the edge that ends the grab. The reference model predicts held_o, ready_o and node_busy_o for every cycle, so any such error is reported in the cycle it first reaches a port.

// File: rtl/commit_arb_pkg.sv
package commit_arb_pkg;

    // Life cycle of one requester's acquisition.
    typedef enum logic [1:0] {
        RQ_IDLE  = 2'd0,   // no request in flight
        RQ_GRAB  = 2'd1,   // one-cycle attempt on the whole set
        RQ_CLIMB = 2'd2,   // ascending, one node per cycle
        RQ_HOLD  = 2'd3    // full set held, may commit
    } rq_state_e;

    // Registered state of one requester.
    typedef struct packed {
        rq_state_e   st;
        logic [31:0] set;
        logic [31:0] held;
    } rq_view_t;

    // Keep only the least significant set bit of a 32-bit word.
    function automatic logic [31:0] lsb_only(input logic [31:0] v);
        return v & (~v + 32'd1);
    endfunction

endpackage

// File: rtl/cna_node_arb.sv
module cna_node_arb #(
    parameter int NUM_REQ = 4
) (
    input  logic [NUM_REQ-1:0] want_i,
    input  logic               busy_i,
    output logic [NUM_REQ-1:0] grant_o
);
    localparam logic [NUM_REQ-1:0] ONE = NUM_REQ'(1);

    // Fixed priority: lowest requester index wins a free node.
    always_comb begin
        if (busy_i) grant_o = '0;
        else        grant_o = want_i & (~want_i + ONE);
    end
endmodule

// File: rtl/cna_req_ctrl.sv
module cna_req_ctrl
    import commit_arb_pkg::*;
#(
    parameter int NUM_NODES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 valid_i,
    input  logic                 spec_i,
    input  logic [NUM_NODES-1:0] set_i,
    input  logic                 done_i,
    input  logic [NUM_NODES-1:0] grant_i,
    output logic [NUM_NODES-1:0] want_o,
    output logic [NUM_NODES-1:0] held_o,
    output logic                 ready_o
);
    localparam logic [NUM_NODES-1:0] ONE = NUM_NODES'(1);

    rq_state_e            st_q, st_d;
    logic [NUM_NODES-1:0] set_q, set_d, held_q, held_d;
    logic [NUM_NODES-1:0] remain, target, miss, miss_lsb, keep;

    always_comb begin
        remain   = set_q & ~held_q;
        target   = remain & (~remain + ONE);
        miss     = set_q & ~grant_i;
        miss_lsb = miss & (~miss + ONE);
        keep     = grant_i & (miss_lsb - ONE);   // granted nodes below first refusal

        want_o = '0;
        st_d   = st_q;
        set_d  = set_q;
        held_d = held_q;

        if (done_i && st_q != RQ_IDLE) begin
            st_d   = RQ_IDLE;
            held_d = '0;
        end else begin
            unique case (st_q)
                RQ_IDLE: begin
                    if (valid_i) begin
                        set_d  = set_i;
                        held_d = '0;
                        st_d   = spec_i ? RQ_GRAB : RQ_CLIMB;
                    end
                end
                RQ_GRAB: begin
                    want_o = set_q;
                    if (miss == '0) begin
                        held_d = set_q;
                        st_d   = RQ_HOLD;
                    end else begin
                        held_d = keep;
                        st_d   = RQ_CLIMB;
                    end
                end
                RQ_CLIMB: begin
                    want_o = target;
                    if (remain == '0) begin
                        st_d = RQ_HOLD;
                    end else begin
                        held_d = held_q | (grant_i & target);
                        if ((remain & ~grant_i) == '0) st_d = RQ_HOLD;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= RQ_IDLE;
            set_q  <= '0;
            held_q <= '0;
        end else begin
            st_q   <= st_d;
            set_q  <= set_d;
            held_q <= held_d;
        end
    end

    assign held_o  = held_q;
    assign ready_o = (st_q == RQ_HOLD);

    // R3: while climbing, nodes are never lost and at most one is added per edge
    assert_climb_step_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == RQ_CLIMB && !done_i) |=>
            (((held_q & $past(held_q)) == $past(held_q)) &&
             ($countones(held_q ^ $past(held_q)) <= 1)));

    // R4: commit permission only with the complete set in hand
    assert_ready_full_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q == RQ_HOLD) |-> (held_q == set_q));

    // R9: done empties the requester on the same edge
    assert_done_frees_R9: assert property (@(posedge clk) disable iff (rst)
        (done_i && st_q != RQ_IDLE) |=> (held_q == '0 && st_q == RQ_IDLE));

    // R10: a new request while holding changes nothing
    assert_busy_ignores_valid_R10: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !done_i && st_q == RQ_HOLD) |=>
            ($stable(set_q) && $stable(held_q) && st_q == RQ_HOLD));
endmodule

// File: rtl/commit_node_arbiter.sv
module commit_node_arbiter
    import commit_arb_pkg::*;
#(
    parameter int NUM_REQ   = 4,
    parameter int NUM_NODES = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_REQ-1:0]             req_valid_i,
    input  logic [NUM_REQ-1:0]             req_spec_i,
    input  logic [NUM_REQ*NUM_NODES-1:0]   req_set_i,
    input  logic [NUM_REQ-1:0]             done_i,
    output logic [NUM_REQ-1:0]             ready_o,
    output logic [NUM_REQ*NUM_NODES-1:0]   held_o,
    output logic [NUM_NODES-1:0]           node_busy_o
);
    logic [NUM_REQ-1:0][NUM_NODES-1:0] want_rn, held_rn, grant_rn;
    logic [NUM_NODES-1:0][NUM_REQ-1:0] want_nr, held_nr, grant_nr;

    // Requester-major to node-major views and back.
    always_comb begin
        for (int r = 0; r < NUM_REQ; r++) begin
            for (int n = 0; n < NUM_NODES; n++) begin
                want_nr[n][r]  = want_rn[r][n];
                held_nr[n][r]  = held_rn[r][n];
                grant_rn[r][n] = grant_nr[n][r];
            end
        end
    end

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
        cna_req_ctrl #(.NUM_NODES(NUM_NODES)) u_req (
            .clk     (clk),
            .rst     (rst),
            .valid_i (req_valid_i[r]),
            .spec_i  (req_spec_i[r]),
            .set_i   (req_set_i[r*NUM_NODES +: NUM_NODES]),
            .done_i  (done_i[r]),
            .grant_i (grant_rn[r]),
            .want_o  (want_rn[r]),
            .held_o  (held_rn[r]),
            .ready_o (ready_o[r])
        );
        assign held_o[r*NUM_NODES +: NUM_NODES] = held_rn[r];
    end

    for (genvar n = 0; n < NUM_NODES; n++) begin : g_node
        assign node_busy_o[n] = |held_nr[n];

        cna_node_arb #(.NUM_REQ(NUM_REQ)) u_arb (
            .want_i  (want_nr[n]),
            .busy_i  (node_busy_o[n]),
            .grant_o (grant_nr[n])
        );

        // R2: owner registers of different requesters never overlap on a node
        assert_node_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
            $onehot0(held_nr[n]));
    end
endmodule

// File: tb/commit_node_arbiter_tb.sv
`timescale 1ns/1ps
module commit_node_arbiter_tb_top;
    localparam int R = 4;
    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst;
    logic [R-1:0]   d_valid, d_spec, d_done;
    logic [R*N-1:0] d_set;
    logic [R-1:0]   ready;
    logic [R*N-1:0] held;
    logic [N-1:0]   busy;

    always #4 clk = ~clk;   // 125 MHz

    commit_node_arbiter #(.NUM_REQ(R), .NUM_NODES(N)) dut_i (
        .clk(clk), .rst(rst), .req_valid_i(d_valid), .req_spec_i(d_spec),
        .req_set_i(d_set), .done_i(d_done), .ready_o(ready), .held_o(held),
        .node_busy_o(busy)
    );

    int vectors = 0;
    int fails   = 0;
    bit finished = 0;

    // Behavioural model: 0 idle, 1 grab, 2 climb, 3 hold
    int       m_st   [R];
    logic [N-1:0] m_set  [R];
    logic [N-1:0] m_held [R];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] low_bit(logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return N'(1) << i;
        return '0;
    endfunction

    task automatic model_step();
        logic [N-1:0] occ, w[R], g[R], rem, miss, fb;
        bit taken;
        occ = '0;
        for (int r = 0; r < R; r++) occ |= m_held[r];
        for (int r = 0; r < R; r++) begin
            w[r] = '0; g[r] = '0;
            if (!d_done[r]) begin
                if (m_st[r] == 1) w[r] = m_set[r];
                else if (m_st[r] == 2) w[r] = low_bit(m_set[r] & ~m_held[r]);
            end
        end
        for (int n = 0; n < N; n++) begin
            taken = 0;
            for (int r = 0; r < R; r++)
                if (!taken && w[r][n] && !occ[n]) begin g[r][n] = 1'b1; taken = 1; end
        end
        for (int r = 0; r < R; r++) begin
            if (d_done[r] && m_st[r] != 0) begin
                m_st[r] = 0; m_held[r] = '0;
            end else if (m_st[r] == 0) begin
                if (d_valid[r]) begin
                    m_set[r] = d_set[r*N +: N]; m_held[r] = '0;
                    m_st[r] = d_spec[r] ? 1 : 2;
                end
            end else if (m_st[r] == 1) begin
                if (g[r] == m_set[r]) begin m_held[r] = m_set[r]; m_st[r] = 3; end
                else begin
                    miss = m_set[r] & ~g[r];
                    fb = low_bit(miss);
                    m_held[r] = g[r] & (fb - N'(1));
                    m_st[r] = 2;
                end
            end else if (m_st[r] == 2) begin
                rem = m_set[r] & ~m_held[r];
                if (rem == '0) m_st[r] = 3;
                else begin
                    m_held[r] |= g[r];
                    if ((m_set[r] & ~m_held[r]) == '0) m_st[r] = 3;
                end
            end
        end
    endtask

    task automatic compare();
        logic [N-1:0] occ;
        occ = '0;
        for (int r = 0; r < R; r++) begin
            occ |= m_held[r];
            check($sformatf("R3 held of requester %0d", r), 32'(held[r*N +: N]), 32'(m_held[r]));
            check($sformatf("R4 ready of requester %0d", r), 32'(ready[r]), 32'(m_st[r] == 3));
        end
        check("R2 node busy map", 32'(busy), 32'(occ));
    endtask

    // One clock: model advances with the DUT, outputs compared at the falling edge.
    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        d_valid = '0; d_done = '0;
    endtask

    task automatic req(int r, logic [N-1:0] s, bit spec);
        d_valid[r] = 1'b1; d_spec[r] = spec; d_set[r*N +: N] = s;
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        d_valid = '0; d_spec = '0; d_done = '0; d_set = '0;
        rst = 1'b1;
        for (int r = 0; r < R; r++) begin m_st[r] = 0; m_set[r] = '0; m_held[r] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 ready after reset", 32'(ready), 0);
        check("R1 held after reset", 32'(held), 0);
        check("R1 busy after reset", 32'(busy), 0);

        // R3 / R4: ordered climb over nodes 2,5,7
        req(0, 8'hA4, 0); tick();
        tick(); check("R3 first node", 32'(held[0 +: N]), 32'h04);
        tick(); check("R3 second node", 32'(held[0 +: N]), 32'h24);
        check("R4 not ready early", 32'(ready[0]), 0);
        tick(); check("R4 ready on 4th edge", 32'(ready[0]), 1);
        d_done[0] = 1; tick();
        check("R9 nodes freed", 32'(busy), 0);

        // R5: disjoint sets in parallel
        req(0, 8'h03, 0); req(1, 8'h0C, 0); tick();
        tick(); tick();
        check("R5 both ready", 32'(ready[1:0]), 32'h3);
        d_done[0] = 1; d_done[1] = 1; tick();

        // R8: same node, same cycle
        req(0, 8'h01, 0); req(1, 8'h01, 0); tick();
        tick();
        check("R8 low index wins", 32'(held[0 +: N]), 32'h01);
        check("R8 high index waits", 32'(held[N +: N]), 0);
        tick(); check("R8 loser not ready", 32'(ready[1]), 0);
        d_done[0] = 1; tick();
        check("R9 not regranted on freeing edge", 32'(held[N +: N]), 0);
        tick(); check("R9 granted next edge", 32'(ready[1]), 1);
        d_done[1] = 1; tick();

        // R6: uncontested speculative grab
        req(2, 8'hF0, 1); tick(); tick();
        check("R6 speculative ready", 32'(ready[2]), 1);
        check("R6 speculative held", 32'(held[2*N +: N]), 32'hF0);
        d_done[2] = 1; tick();

        // R7: speculative fallback keeps only the prefix below the refused node
        req(0, 8'h04, 0); tick(); tick();
        req(1, 8'h17, 1); tick(); tick();
        check("R7 prefix kept", 32'(held[N +: N]), 32'h03);
        check("R7 upper node left free", 32'(busy), 32'h07);
        tick(); check("R7 still waiting", 32'(ready[1]), 0);
        d_done[0] = 1; tick();
        tick(); check("R7 climbs to node 2", 32'(held[N +: N]), 32'h07);
        tick(); check("R7 completes", 32'(ready[1]), 1);
        d_done[1] = 1; tick();

        // R10: valid while holding, done while idle
        req(3, 8'h80, 0); tick(); tick();
        req(3, 8'h01, 1); tick();
        check("R10 set unchanged", 32'(held[3*N +: N]), 32'h80);
        check("R10 still ready", 32'(ready[3]), 1);
        d_done[2] = 1; tick();
        check("R10 idle done no effect", 32'(busy), 32'h80);
        d_done[3] = 1; tick();

        // R11: empty set in both modes
        req(2, 8'h00, 0); req(1, 8'h00, 1); tick(); tick();
        check("R11 empty ordered", 32'(ready[2]), 1);
        check("R11 empty speculative", 32'(ready[1]), 1);
        d_done[2] = 1; d_done[1] = 1; tick();

        // Random traffic against the model (R2, R3, R4, R7, R8 under contention)
        for (int c = 0; c < 3000; c++) begin
            for (int r = 0; r < R; r++) begin
                if (m_st[r] == 0 && $urandom % 4 == 0) req(r, 8'($urandom), 1'($urandom));
                else if (m_st[r] == 3 && $urandom % 3 == 0) d_done[r] = 1'b1;
                else if (m_st[r] != 0 && $urandom % 40 == 0) d_done[r] = 1'b1;
                else if (m_st[r] != 0 && $urandom % 8 == 0) req(r, 8'($urandom), 1'($urandom));
            end
            tick();
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule